// File: doc/BRIEF.md
# Acquisition Command Sequencer

This block runs a short program of acquisition commands each time a record trigger arrives. A bank of command words is written through a simple write port. On a trigger the block fetches the words one after another from slot 0. For each word it sets the capacitor switch controls (discharge, charge, balance). It may pulse a conversion start and may call a math sequence by index. It sets the override state of one sense pin and three transmit pin groups, and it presents the word's DMA request flags. It then waits on the source that the word selects before moving on.

A wait can run on one of three list timers or on a short delay count. A wait can also hold until the external converter reports that it has finished. The converter, the analog switches and the math engine are outside the block and are reached through pulse and level ports. A run ends after a word that carries the end flag. If no word in the bank carries it, the run ends after the last slot. The busy output covers the whole run, and any trigger seen while busy is dropped.

Top module: `acq_cmd_seq`

## Requirements
- R1: A trigger seen while idle starts a run at slot 0 and raises busy on the next clock. Each executed command keeps busy high for three clocks plus its wait count.
- R2: A run ends after the first command whose end flag (bit 25) is set. Busy falls and no later slot is executed.
- R3: If no end flag is found, the run ends after slot 15. With no waits this gives 48 busy clocks.
- R4: The 4-bit wait field (bits 15:12) works as follows. Codes 0, 1 and 2 count down list timer 0, 1 or 2 (timer n is list_tmr_i[8n+7:8n]). Code 3 counts down dly_i. Code 4 waits for conversion done. Any other code means no wait. A count of N adds N clocks.
- R5: With wait code 4 the command completes on the first wait clock in which conv_done_i is high. It stays in place for as long as that input is low.
- R6: A command whose conversion flag (bit 16) is set gives a single-clock conv_start_o pulse, but only when its balance flag (bit 17) is also set. Without balance, no pulse is produced.
- R7: A command whose math flag (bit 24) is set gives a single-clock math_start_o pulse, and math_seq_o shows the 4-bit index from bits 23:20.
- R8: Each 2-bit pin code maps to {ovr,oe,lvl} as follows: 0 gives 000 (normal port control), 1 gives 110 (drive low), 2 gives 111 (drive high) and 3 gives 100 (tri-state). Pin 0 is the sense pin (bits 11:10). Pins 1 to 3 are transmit groups A, B and C (bits 9:8, 7:6 and 5:4).
- R9: After reset all switch, pin, pulse and DMA outputs are 0 and busy is low. The switch, pin and DMA outputs keep the last command's values until the next command is loaded, including after the run ends.
- R10: A trigger that arrives while busy is high is ignored. This includes the clock in which the final command completes.
- R11: A write through the command port replaces a slot, and the next run uses the new word.
- R12: Switch outputs {dis,chg,bal} come from bits 19, 18 and 17. dma_o comes from bits 3:0 of the current command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Record trigger |
| cmd_we_i | input | 1 | Command slot write enable |
| cmd_addr_i | input | 4 | Command slot address |
| cmd_wdata_i | input | 26 | Command word to write |
| list_tmr_i | input | 24 | Three list timer reload values, 8 bits each |
| dly_i | input | 5 | Delay count reload value |
| conv_done_i | input | 1 | Converter finished |
| busy_o | output | 1 | Run in progress |
| sw_dis_o | output | 1 | Discharge switch |
| sw_chg_o | output | 1 | Charge switch |
| sw_bal_o | output | 1 | Balance switch |
| conv_start_o | output | 1 | Conversion start pulse |
| math_start_o | output | 1 | Math sequence start pulse |
| math_seq_o | output | 4 | Math sequence index |
| pin_ovr_o | output | 4 | Pin override active (sense, A, B, C) |
| pin_oe_o | output | 4 | Pin output enable when overridden |
| pin_lvl_o | output | 4 | Pin drive level when overridden |
| dma_o | output | 4 | DMA request flags of current command |

## Verification
The case that needs care is a fresh record trigger arriving in the same clock in which the final command's wait completes and the block returns to idle. The bench starts a single-command run with no wait and raises the trigger for exactly the third clock of the run. It then requires busy to fall on the following clock and stay low for several more clocks. A second trigger pulse in the middle of a timed run is judged by the total busy length, which must match a single run.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

  localparam int MSEQ_W    = 4;
  localparam int WSEL_W    = 4;
  localparam int PINS      = 4;
  localparam int DMA_W     = 4;
  localparam int WSEL_DLY  = 3;
  localparam int WSEL_CONV = 4;
  localparam int NUM_TMR   = WSEL_DLY;

  typedef struct packed {
    logic              end_f;   // 25
    logic              math_f;  // 24
    logic [MSEQ_W-1:0] mseq;    // 23:20
    logic              dis;     // 19
    logic              chg;     // 18
    logic              bal;     // 17
    logic              conv;    // 16
    logic [WSEL_W-1:0] wsel;    // 15:12
    logic [1:0]        pc_s;    // 11:10
    logic [1:0]        pc_a;    // 9:8
    logic [1:0]        pc_b;    // 7:6
    logic [1:0]        pc_c;    // 5:4
    logic [DMA_W-1:0]  dma;     // 3:0
  } acq_cmd_t;

  localparam int CMD_W = $bits(acq_cmd_t);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_LOAD, S_WAIT} seq_state_t;
  typedef enum logic [1:0] {WM_NONE, WM_COUNT, WM_CONV} wait_mode_t;

endpackage

// File: rtl/acq_cmd_mem.sv
module acq_cmd_mem #(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 26,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WIDTH-1:0]  rdata_o
);

  logic [WIDTH-1:0] mem [DEPTH];

  // Write-first not needed; plain synchronous read for block RAM.
  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/acq_wait_timer.sv
module acq_wait_timer
  import acq_seq_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int DLY_W = 5,
  parameter int CNT_W = (TMR_W > DLY_W) ? TMR_W : DLY_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_i,
  input  logic [WSEL_W-1:0]        wsel_i,
  input  logic [NUM_TMR*TMR_W-1:0] tmr_i,
  input  logic [DLY_W-1:0]         dly_i,
  input  logic                     waiting_i,
  input  logic                     conv_done_i,
  output logic                     done_o
);

  logic [TMR_W-1:0] tmr_arr [NUM_TMR];
  logic [TMR_W-1:0] sel_tmr;
  logic             sel_is_tmr;
  logic [CNT_W-1:0] cnt;
  wait_mode_t       mode;

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    assign tmr_arr[g] = tmr_i[g*TMR_W +: TMR_W];
  end

  always_comb begin
    sel_tmr    = '0;
    sel_is_tmr = 1'b0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (wsel_i == WSEL_W'(i)) begin
        sel_tmr    = tmr_arr[i];
        sel_is_tmr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= WM_NONE;
      cnt  <= '0;
    end else if (load_i) begin
      if (sel_is_tmr) begin
        mode <= WM_COUNT;
        cnt  <= CNT_W'(sel_tmr);
      end else if (wsel_i == WSEL_W'(WSEL_DLY)) begin
        mode <= WM_COUNT;
        cnt  <= CNT_W'(dly_i);
      end else if (wsel_i == WSEL_W'(WSEL_CONV)) begin
        mode <= WM_CONV;
        cnt  <= '0;
      end else begin
        mode <= WM_NONE;
        cnt  <= '0;
      end
    end else if (waiting_i && mode == WM_COUNT && cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign done_o = waiting_i &&
                  ((mode == WM_NONE) ||
                   (mode == WM_COUNT && cnt == '0) ||
                   (mode == WM_CONV && conv_done_i));

  // R4: a running count steps down by exactly one each waiting clock
  p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
    (waiting_i && !load_i && mode == WM_COUNT && cnt != '0) |=>
      (cnt == $past(cnt) - CNT_W'(1)));

  // R5: a conversion wait never finishes while the converter is busy
  p_conv_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (waiting_i && mode == WM_CONV && !conv_done_i) |-> !done_o);

endmodule

// File: rtl/acq_pin_drive.sv
module acq_pin_drive (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_i,
  input  logic [1:0] code_i,
  output logic       ovr_o,
  output logic       oe_o,
  output logic       lvl_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_o <= 1'b0;
      oe_o  <= 1'b0;
      lvl_o <= 1'b0;
    end else if (load_i) begin
      case (code_i)
        2'd1:    begin ovr_o <= 1'b1; oe_o <= 1'b1; lvl_o <= 1'b0; end
        2'd2:    begin ovr_o <= 1'b1; oe_o <= 1'b1; lvl_o <= 1'b1; end
        2'd3:    begin ovr_o <= 1'b1; oe_o <= 1'b0; lvl_o <= 1'b0; end
        default: begin ovr_o <= 1'b0; oe_o <= 1'b0; lvl_o <= 1'b0; end
      endcase
    end
  end

  // R8: a released pin never drives
  p_release_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !ovr_o |-> (!oe_o && !lvl_o));

  // R9: pin state only moves when a command is loaded
  p_pin_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable({ovr_o, oe_o, lvl_o}));

endmodule

// File: rtl/acq_cmd_seq.sv
module acq_cmd_seq
  import acq_seq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TMR_W  = 8,
  parameter int DLY_W  = 5,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     trig_i,
  input  logic                     cmd_we_i,
  input  logic [ADDR_W-1:0]        cmd_addr_i,
  input  logic [CMD_W-1:0]         cmd_wdata_i,
  input  logic [NUM_TMR*TMR_W-1:0] list_tmr_i,
  input  logic [DLY_W-1:0]         dly_i,
  input  logic                     conv_done_i,
  output logic                     busy_o,
  output logic                     sw_dis_o,
  output logic                     sw_chg_o,
  output logic                     sw_bal_o,
  output logic                     conv_start_o,
  output logic                     math_start_o,
  output logic [MSEQ_W-1:0]        math_seq_o,
  output logic [PINS-1:0]          pin_ovr_o,
  output logic [PINS-1:0]          pin_oe_o,
  output logic [PINS-1:0]          pin_lvl_o,
  output logic [DMA_W-1:0]         dma_o
);

  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(DEPTH - 1);

  seq_state_t        state;
  logic [ADDR_W-1:0] idx;
  logic              stop_q;
  logic [CMD_W-1:0]  rdata;
  acq_cmd_t          rd;
  logic              load;
  logic              waiting;
  logic              wait_done;
  logic [1:0]        pin_code [PINS];

  assign rd      = acq_cmd_t'(rdata);
  assign load    = (state == S_LOAD);
  assign waiting = (state == S_WAIT);

  acq_cmd_mem #(.DEPTH(DEPTH), .WIDTH(CMD_W), .ADDR_W(ADDR_W)) u_mem (
    .clk     (clk),
    .we_i    (cmd_we_i),
    .waddr_i (cmd_addr_i),
    .wdata_i (cmd_wdata_i),
    .raddr_i (idx),
    .rdata_o (rdata)
  );

  acq_wait_timer #(.TMR_W(TMR_W), .DLY_W(DLY_W)) u_wait (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load),
    .wsel_i      (rd.wsel),
    .tmr_i       (list_tmr_i),
    .dly_i       (dly_i),
    .waiting_i   (waiting),
    .conv_done_i (conv_done_i),
    .done_o      (wait_done)
  );

  assign pin_code[0] = rd.pc_s;
  assign pin_code[1] = rd.pc_a;
  assign pin_code[2] = rd.pc_b;
  assign pin_code[3] = rd.pc_c;

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    acq_pin_drive u_pin (
      .clk    (clk),
      .rst    (rst),
      .load_i (load),
      .code_i (pin_code[p]),
      .ovr_o  (pin_ovr_o[p]),
      .oe_o   (pin_oe_o[p]),
      .lvl_o  (pin_lvl_o[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      idx          <= '0;
      stop_q       <= 1'b0;
      busy_o       <= 1'b0;
      sw_dis_o     <= 1'b0;
      sw_chg_o     <= 1'b0;
      sw_bal_o     <= 1'b0;
      conv_start_o <= 1'b0;
      math_start_o <= 1'b0;
      math_seq_o   <= '0;
      dma_o        <= '0;
    end else begin
      conv_start_o <= 1'b0;
      math_start_o <= 1'b0;
      case (state)
        S_IDLE: begin
          if (trig_i) begin
            state  <= S_FETCH;
            idx    <= '0;
            busy_o <= 1'b1;
          end
        end
        S_FETCH: state <= S_LOAD;
        S_LOAD: begin
          sw_dis_o     <= rd.dis;
          sw_chg_o     <= rd.chg;
          sw_bal_o     <= rd.bal;
          conv_start_o <= rd.conv & rd.bal;
          math_start_o <= rd.math_f;
          if (rd.math_f) math_seq_o <= rd.mseq;
          dma_o        <= rd.dma;
          stop_q       <= rd.end_f || (idx == LAST_IDX);
          state        <= S_WAIT;
        end
        default: begin
          if (wait_done) begin
            if (stop_q) begin
              state  <= S_IDLE;
              busy_o <= 1'b0;
            end else begin
              idx   <= idx + 1'b1;
              state <= S_FETCH;
            end
          end
        end
      endcase
    end
  end

  // R6: a conversion is only started with the balance switch closed
  p_conv_bal_r6: assert property (@(posedge clk) disable iff (rst)
    conv_start_o |-> sw_bal_o);

  // R7: math start is a single-clock pulse
  p_math_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    math_start_o |=> !math_start_o);

  // R1: busy rises only in answer to a trigger
  p_start_trig_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(trig_i));

  // R9: switch outputs are held outside the load step
  p_sw_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable({sw_dis_o, sw_chg_o, sw_bal_o, dma_o}));

  // R10: idle is only left through a trigger and always raises busy
  p_idle_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !trig_i) |=> (state == S_IDLE && !busy_o));

endmodule

// File: tb/acq_cmd_seq_tb.sv
`timescale 1ns/1ps
module acq_cmd_seq_tb;
  import acq_seq_pkg::*;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                trig_i = 1'b0;
  logic                cmd_we_i = 1'b0;
  logic [3:0]          cmd_addr_i = '0;
  logic [CMD_W-1:0]    cmd_wdata_i = '0;
  logic [23:0]         list_tmr_i = {8'd2, 8'd9, 8'd5};
  logic [4:0]          dly_i = 5'd7;
  logic                conv_done_i = 1'b0;
  logic                busy_o, sw_dis_o, sw_chg_o, sw_bal_o;
  logic                conv_start_o, math_start_o;
  logic [3:0]          math_seq_o, pin_ovr_o, pin_oe_o, pin_lvl_o, dma_o;

  int n_checks = 0;
  int n_fail   = 0;
  int n_conv   = 0;
  int n_math   = 0;
  bit done_all = 1'b0;

  always #10 clk = ~clk;

  acq_cmd_seq u_dut (
    .clk (clk), .rst (rst), .trig_i (trig_i),
    .cmd_we_i (cmd_we_i), .cmd_addr_i (cmd_addr_i), .cmd_wdata_i (cmd_wdata_i),
    .list_tmr_i (list_tmr_i), .dly_i (dly_i), .conv_done_i (conv_done_i),
    .busy_o (busy_o), .sw_dis_o (sw_dis_o), .sw_chg_o (sw_chg_o), .sw_bal_o (sw_bal_o),
    .conv_start_o (conv_start_o), .math_start_o (math_start_o), .math_seq_o (math_seq_o),
    .pin_ovr_o (pin_ovr_o), .pin_oe_o (pin_oe_o), .pin_lvl_o (pin_lvl_o), .dma_o (dma_o)
  );

  always @(posedge clk) begin
    if (!rst) begin
      if (conv_start_o) n_conv <= n_conv + 1;
      if (math_start_o) n_math <= n_math + 1;
    end
  end

  // wsel, pin codes s/a/b/c, sw {dis,chg,bal}, dma, busy length, expected ovr/oe/lvl
  typedef struct packed {
    logic [3:0] wsel;
    logic [1:0] ps, pa, pb, pc;
    logic [2:0] sw;
    logic [3:0] dma;
    logic [7:0] len;
    logic [3:0] ovr, oe, lvl;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'd0,  2'd1, 2'd2, 2'd3, 2'd0, 3'b101, 4'b0001, 8'd8,  4'b0111, 4'b0011, 4'b0010},
    '{4'd1,  2'd2, 2'd0, 2'd1, 2'd3, 3'b010, 4'b1000, 8'd12, 4'b1101, 4'b0101, 4'b0001},
    '{4'd2,  2'd3, 2'd3, 2'd2, 2'd1, 3'b001, 4'b0110, 8'd5,  4'b1111, 4'b1100, 4'b0100},
    '{4'd3,  2'd0, 2'd1, 2'd2, 2'd2, 3'b100, 4'b1111, 8'd10, 4'b1110, 4'b1110, 4'b1100},
    '{4'd9,  2'd0, 2'd0, 2'd0, 2'd0, 3'b000, 4'b0000, 8'd3,  4'b0000, 4'b0000, 4'b0000},
    '{4'd15, 2'd2, 2'd2, 2'd2, 2'd2, 3'b111, 4'b0101, 8'd3,  4'b1111, 4'b1111, 4'b1111}
  };

  function automatic acq_cmd_t mk(logic e, logic m, logic [3:0] ms, logic [2:0] sw,
                                  logic cv, logic [3:0] ws, logic [1:0] ps, logic [1:0] pa,
                                  logic [1:0] pb, logic [1:0] pc, logic [3:0] d);
    acq_cmd_t c;
    c.end_f = e; c.math_f = m; c.mseq = ms;
    c.dis = sw[2]; c.chg = sw[1]; c.bal = sw[0]; c.conv = cv;
    c.wsel = ws; c.pc_s = ps; c.pc_a = pa; c.pc_b = pb; c.pc_c = pc; c.dma = d;
    return c;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int addr, acq_cmd_t c);
    @(negedge clk);
    cmd_we_i = 1'b1; cmd_addr_i = 4'(addr); cmd_wdata_i = c;
    @(negedge clk);
    cmd_we_i = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_i = 1'b1;
    @(negedge clk); trig_i = 1'b0;
  endtask

  task automatic run(output int len);
    pulse_trig();
    len = 0;
    while (busy_o && len < 2000) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_all) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int len, m0, c0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk("R9 reset busy", int'(busy_o), 0);
    chk("R9 reset outputs", int'({sw_dis_o, sw_chg_o, sw_bal_o, conv_start_o, math_start_o,
                                  pin_ovr_o, pin_oe_o, pin_lvl_o, dma_o}), 0);

    // Vector table: R1 R4 R8 R9 R11 R12
    for (int v = 0; v < 6; v++) begin
      wr(0, mk(1'b1, 1'b0, 4'd0, VECS[v].sw, 1'b0, VECS[v].wsel,
               VECS[v].ps, VECS[v].pa, VECS[v].pb, VECS[v].pc, VECS[v].dma));
      run(len);
      chk("R1/R4/R11 busy length", len, int'(VECS[v].len));
      chk("R8/R9 pin ovr", int'(pin_ovr_o), int'(VECS[v].ovr));
      chk("R8/R9 pin oe",  int'(pin_oe_o),  int'(VECS[v].oe));
      chk("R8/R9 pin lvl", int'(pin_lvl_o), int'(VECS[v].lvl));
      chk("R12 switches", int'({sw_dis_o, sw_chg_o, sw_bal_o}), int'(VECS[v].sw));
      chk("R12 dma flags", int'(dma_o), int'(VECS[v].dma));
    end

    // R7: math call
    wr(0, mk(1'b1, 1'b1, 4'd11, 3'b000, 1'b0, 4'd9, 2'd0, 2'd0, 2'd0, 2'd0, 4'd0));
    m0 = n_math;
    run(len);
    chk("R7 math pulses", n_math - m0, 1);
    chk("R7 math index", int'(math_seq_o), 11);

    // R5 R6: conversion with balance, wait for done
    wr(0, mk(1'b1, 1'b0, 4'd0, 3'b001, 1'b1, 4'd4, 2'd0, 2'd0, 2'd0, 2'd0, 4'd0));
    c0 = n_conv;
    pulse_trig();
    repeat (6) @(negedge clk);
    chk("R5 held while conversion busy", int'(busy_o), 1);
    conv_done_i = 1'b1;
    @(negedge clk);
    conv_done_i = 1'b0;
    chk("R5 ends on conversion done", int'(busy_o), 0);
    chk("R6 conv pulse with balance", n_conv - c0, 1);

    // R6: conversion flag without balance
    wr(0, mk(1'b1, 1'b0, 4'd0, 3'b000, 1'b1, 4'd9, 2'd0, 2'd0, 2'd0, 2'd0, 4'd0));
    c0 = n_conv;
    run(len);
    chk("R6 no conv pulse without balance", n_conv - c0, 0);

    // R2: end flag on slot 2 stops before slot 3
    for (int s = 0; s < 4; s++)
      wr(s, mk(s == 2, 1'b1, 4'(s), 3'b000, 1'b0, 4'd9, 2'd0, 2'd0, 2'd0, 2'd0, 4'd0));
    m0 = n_math;
    run(len);
    chk("R2 busy length", len, 9);
    chk("R2 commands executed", n_math - m0, 3);

    // R3: no end flag anywhere
    for (int s = 0; s < 16; s++)
      wr(s, mk(1'b0, 1'b1, 4'(s), 3'b000, 1'b0, 4'd9, 2'd0, 2'd0, 2'd0, 2'd0, 4'd0));
    m0 = n_math;
    run(len);
    chk("R3 busy length", len, 48);
    chk("R3 commands executed", n_math - m0, 16);
    chk("R3 last math index", int'(math_seq_o), 15);

    // R10: trigger mid-run on a timer-0 command (5 clocks)
    wr(0, mk(1'b1, 1'b0, 4'd0, 3'b000, 1'b0, 4'd0, 2'd0, 2'd0, 2'd0, 2'd0, 4'd0));
    len = 0;
    pulse_trig();
    repeat (2) begin len++; @(negedge clk); end
    trig_i = 1'b1; len++;
    @(negedge clk);
    trig_i = 1'b0;
    while (busy_o && len < 2000) begin len++; @(negedge clk); end
    chk("R10 mid-run trigger ignored", len, 8);

    // R10: trigger in the completion clock
    wr(0, mk(1'b1, 1'b0, 4'd0, 3'b000, 1'b0, 4'd9, 2'd0, 2'd0, 2'd0, 2'd0, 4'd0));
    pulse_trig();
    repeat (2) @(negedge clk);
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
    len = int'(busy_o);
    repeat (4) begin
      @(negedge clk);
      len += int'(busy_o);
    end
    chk("R10 completion-clock trigger ignored", len, 0);

    done_all = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule